// File: doc/BRIEF.md
# Multi-Channel Match Timer Bank

The block holds eight match channels, numbered 4 to 11. Each channel has a 32-bit up-counter, a 32-bit match value and a small control word. The control word selects which of five tick-enable inputs advances the counter. It also sets three things: whether the match compares against the channel's own counter or a shared group counter, whether the channel's counter clears on a match, and whether the match re-arms after it fires. The tick strobes are single-cycle enables made outside the block, and each one advances a counter by one.

A write to a match value arms that channel. A match fires in the cycle when the compared counter steps onto the match value. If the channel's enable bit is set, the match latches a status bit whose position equals the channel number. A single level interrupt follows the OR of the latched status bits. Reading certain counters can also copy a neighbouring counter into a snapshot register, so that two counters can be sampled together.

Top module: `tmr_bank`

## Requirements
- R1: After reset every counter, match value, control word, enable mask, status and snapshot reads 0, and `irq_o` is low.
- R2: The control bits [2:0] pick the rate: code 1 selects `tick_i[0]`, 2 selects `tick_i[1]`, 3 selects `tick_i[2]`, 4 selects `tick_i[3]` and 5 selects `tick_i[4]`. The counter advances by exactly one per strobe of the selected input and ignores every other tick input.
- R3: Rate codes 0, 6 and 7 stop the counter, and so does control bit 8 on channels 8 to 11. A stopped counter keeps its value and reads return that value.
- R4: A bus write to a counter takes precedence over an increment in the same cycle. The counter then holds the written value.
- R5: Control words for channels 4 to 7 keep bits [7:0]. Those for channels 8 to 11 keep bits [9:0]. Bits above the kept width read as 0.
- R6: A match fires in the cycle when the compared counter advances onto the armed match value. The match sets status bit n (n = channel number) only if enable bit n is set. Status reads at 0x14 and the enable mask at 0x1C, with bits 4 to 11 in use.
- R7: With control bit 7 set, a channel compares against its own counter. With it clear, channels 5 to 7 compare against counter 4 and channels 8 to 11 compare against counter 6. Channel 4 always uses its own counter.
- R8: With control bit 3 set, the channel's own counter is 0 in the cycle after its match fires.
- R9: With control bit 6 set, the match stays armed and fires again each time the value is reached. With it clear, the match fires once and then stays quiet until the match register is written again.
- R10: `irq_o` is high while any status bit is set. Writing 1 to a status bit at 0x14 clears that bit.
- R11: Reading counter 9 (0x54) while channel 9 has control bit 9 set copies counter 8 into the snapshot register at 0x20. Reading counter 11 (0x5C) while channel 11 has control bit 9 set copies counter 10 in the same way. Without that bit the snapshot keeps its value.

Register offsets for channel n: counter 0x40+4(n-4), match 0x80+4(n-4), control 0xC0+4(n-4). Read data is combinational from `addr_i`. A write takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 5 | Single-cycle rate strobes (32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external) |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (triggers snapshot capture) |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Combined match interrupt |

## Verification
The rate selector is tried in three ways. All five tick inputs are pulsed one at a time against channels set to different codes, which shows whether the right strobe feeds each channel. All inputs are also pulsed together against stopped codes and the hold bit, which separates a true stop from an unselected rate. Match tests place the same counter values against a private counter, a group counter in each half of the bank, once and periodic modes, and an enabled and a masked status bit. Each case shows which counter a channel compares and whether the status comes from the channel itself. The snapshot is read with the capture bit both set and clear, to tell a copy from a stale value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 8;
  localparam int unsigned NTICK  = 5;
  localparam int unsigned CTRL_W = 10;

  localparam logic [AW-1:0] A_STAT = 8'h14;
  localparam logic [AW-1:0] A_IEN  = 8'h1C;
  localparam logic [AW-1:0] A_SNAP = 8'h20;
  localparam logic [AW-1:0] A_CNT  = 8'h40;
  localparam logic [AW-1:0] A_MAT  = 8'h80;
  localparam logic [AW-1:0] A_CTL  = 8'hC0;

  // control word bit positions
  localparam int unsigned C_CLR  = 3;
  localparam int unsigned C_PER  = 6;
  localparam int unsigned C_OWN  = 7;
  localparam int unsigned C_HOLD = 8;
  localparam int unsigned C_SNAP = 9;

  function automatic logic [AW-1:0] slot(input logic [AW-1:0] base, input int unsigned idx);
    return base + AW'(idx * 4);
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
  parameter bit          ALWAYS_OWN = 1'b0,
  parameter int unsigned KEEP_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NTICK-1:0]  tick_i,
  input  logic              cnt_we_i,
  input  logic              match_we_i,
  input  logic              ctrl_we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     shr_cnt_i,
  input  logic              shr_inc_i,
  output logic [DW-1:0]     cnt_o,
  output logic [DW-1:0]     match_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              inc_o,
  output logic              hit_o
);
  localparam logic [CTRL_W-1:0] KEEP_MASK = CTRL_W'((1 << KEEP_W) - 1);

  logic [DW-1:0]     cnt_q, match_q, cmp_cnt;
  logic [CTRL_W-1:0] ctrl_q;
  logic              armed_q, rate_tick, own_sel, cmp_inc;
  logic [2:0]        rate;

  assign rate = ctrl_q[2:0];

  always_comb begin
    rate_tick = 1'b0;
    if (rate != 3'd0 && 32'(rate) <= NTICK) rate_tick = tick_i[rate - 3'd1];
  end

  assign inc_o   = rate_tick && !ctrl_q[C_HOLD] && !cnt_we_i;
  assign own_sel = ALWAYS_OWN || ctrl_q[C_OWN];
  assign cmp_cnt = own_sel ? cnt_q : shr_cnt_i;
  assign cmp_inc = own_sel ? inc_o : shr_inc_i;
  assign hit_o   = armed_q && cmp_inc && !match_we_i && (cmp_cnt + DW'(1) == match_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= '0;
      ctrl_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_we_i)                   cnt_q <= wdata_i;
      else if (hit_o && ctrl_q[C_CLR]) cnt_q <= '0;
      else if (inc_o)                 cnt_q <= cnt_q + DW'(1);

      if (ctrl_we_i) ctrl_q <= wdata_i[CTRL_W-1:0] & KEEP_MASK;

      if (match_we_i) begin
        match_q <= wdata_i;
        armed_q <= 1'b1;
      end else if (hit_o && !ctrl_q[C_PER]) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign match_o = match_q;
  assign ctrl_o  = ctrl_q;

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(wdata_i)); // R4
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate == 3'd0 && !cnt_we_i && !hit_o) |=> $stable(cnt_o)); // R3
  AST_CLR_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && ctrl_q[C_CLR] && !cnt_we_i) |=> cnt_o == '0); // R8
  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !ctrl_q[C_PER] && !ctrl_we_i) |=> !hit_o); // R9
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] hit_i,
  input  logic           en_we_i,
  input  logic           st_we_i,
  input  logic [NCH-1:0] sel_i,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] st_o,
  output logic           irq_o
);
  logic [NCH-1:0] en_q, st_q, set_v, clr_v;

  assign set_v = hit_i & en_q;
  assign clr_v = st_we_i ? sel_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_we_i) en_q <= sel_i;
      st_q <= (st_q & ~clr_v) | set_v;  // new match beats a same-cycle clear
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign irq_o = |st_q;

  AST_STATUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hit_i & en_o)) |=> ((st_o & $past(hit_i & en_o)) == $past(hit_i & en_o))); // R6
  AST_STATUS_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hit_i & ~en_o)) |=> ((st_o & ~$past(st_o) & $past(hit_i & ~en_o)) == '0)); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !st_we_i) |=> irq_o); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !(|(hit_i & en_o))) |=> !irq_o); // R10
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank import tmr_pkg::*; #(
  parameter int unsigned NCH       = 8,
  parameter int unsigned CH_BASE   = 4,
  parameter int unsigned WIDE_FROM = 8,
  parameter int unsigned NARROW_W  = 8,
  parameter int unsigned SHARE_LO  = 4,
  parameter int unsigned SHARE_HI  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTICK-1:0] tick_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o
);
  logic [DW-1:0]     cnt   [NCH];
  logic [DW-1:0]     match [NCH];
  logic [CTRL_W-1:0] ctrl  [NCH];
  logic [NCH-1:0]    inc, hit, cnt_we, mat_we, ctl_we, snap_req, st, en;
  logic [DW-1:0]     snap_q, snap_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int unsigned CHN  = CH_BASE + i;
    localparam bit          WIDE = CHN >= WIDE_FROM;
    localparam int unsigned SRC  = WIDE ? SHARE_HI - CH_BASE : SHARE_LO - CH_BASE;

    assign cnt_we[i] = we_i && addr_i == slot(A_CNT, i);
    assign mat_we[i] = we_i && addr_i == slot(A_MAT, i);
    assign ctl_we[i] = we_i && addr_i == slot(A_CTL, i);

    tmr_chan #(
      .ALWAYS_OWN (CHN == SHARE_LO),
      .KEEP_W     (WIDE ? CTRL_W : NARROW_W)
    ) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .cnt_we_i   (cnt_we[i]),
      .match_we_i (mat_we[i]),
      .ctrl_we_i  (ctl_we[i]),
      .wdata_i    (wdata_i),
      .shr_cnt_i  (cnt[SRC]),
      .shr_inc_i  (inc[SRC]),
      .cnt_o      (cnt[i]),
      .match_o    (match[i]),
      .ctrl_o     (ctrl[i]),
      .inc_o      (inc[i]),
      .hit_o      (hit[i])
    );

    // odd wide channels capture the counter just below them when read
    if (WIDE && (CHN % 2) == 1 && i > 0) begin : g_snap
      assign snap_req[i] = re_i && addr_i == slot(A_CNT, i) && ctrl[i][C_SNAP];
      AST_SNAP_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snap_req[i] |=> snap_q == $past(cnt[i-1])); // R11
    end else begin : g_nosnap
      assign snap_req[i] = 1'b0;
    end
  end

  always_comb begin
    snap_d = snap_q;
    for (int i = 1; i < NCH; i++) if (snap_req[i]) snap_d = cnt[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else         snap_q <= snap_d;
  end

  tmr_irq #(.NCH(NCH)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .en_we_i (we_i && addr_i == A_IEN),
    .st_we_i (we_i && addr_i == A_STAT),
    .sel_i   (wdata_i[CH_BASE +: NCH]),
    .en_o    (en),
    .st_o    (st),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_STAT) rdata_o = DW'(st) << CH_BASE;
    if (addr_i == A_IEN)  rdata_o = DW'(en) << CH_BASE;
    if (addr_i == A_SNAP) rdata_o = snap_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == slot(A_CNT, i)) rdata_o = cnt[i];
      if (addr_i == slot(A_MAT, i)) rdata_o = match[i];
      if (addr_i == slot(A_CTL, i)) rdata_o = DW'(ctrl[i]);
    end
  end

  AST_SNAP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|snap_req) |=> $stable(snap_q)); // R11
endmodule

// File: tb/tmr_bank_test.sv
module tmr_bank_test;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read-check, 2 tick pulses (a = count, d = mask)
    logic [3:0]  req;
    logic [7:0]  a;
    logic [31:0] d;
  } step_t;

  localparam int NSTEP = 33;
  localparam step_t STEPS [NSTEP] = '{
    '{2'd0, 4'd2, 8'hC0, 32'h01},
    '{2'd2, 4'd2, 8'd5,  32'h01},
    '{2'd1, 4'd2, 8'h40, 32'd5},    // R2 32k strobes
    '{2'd2, 4'd2, 8'd3,  32'h02},
    '{2'd1, 4'd2, 8'h40, 32'd5},    // R2 other rate ignored
    '{2'd0, 4'd2, 8'hC4, 32'h82},
    '{2'd2, 4'd2, 8'd2,  32'h03},
    '{2'd1, 4'd2, 8'h40, 32'd7},    // R2
    '{2'd1, 4'd2, 8'h44, 32'd2},    // R2 1k strobes
    '{2'd0, 4'd3, 8'hD0, 32'h185},
    '{2'd2, 4'd3, 8'd4,  32'h1F},
    '{2'd1, 4'd3, 8'h50, 32'd0},    // R3 hold bit on ch8
    '{2'd1, 4'd5, 8'hD0, 32'h185},  // R5 wide control
    '{2'd0, 4'd5, 8'hC8, 32'h3FF},
    '{2'd1, 4'd5, 8'hC8, 32'hFF},   // R5 narrow control
    '{2'd1, 4'd2, 8'h40, 32'd11},   // R2
    '{2'd1, 4'd2, 8'h44, 32'd6},    // R2
    '{2'd0, 4'd3, 8'hC4, 32'h00},
    '{2'd2, 4'd3, 8'd2,  32'h1F},
    '{2'd1, 4'd3, 8'h44, 32'd6},    // R3 code 0
    '{2'd0, 4'd3, 8'hC4, 32'h07},
    '{2'd2, 4'd3, 8'd2,  32'h1F},
    '{2'd1, 4'd3, 8'h44, 32'd6},    // R3 code 7
    '{2'd0, 4'd2, 8'hC0, 32'h05},
    '{2'd2, 4'd2, 8'd3,  32'h10},
    '{2'd1, 4'd2, 8'h40, 32'd18},   // R2 external strobe
    '{2'd0, 4'd2, 8'hCC, 32'h83},
    '{2'd2, 4'd2, 8'd2,  32'h04},
    '{2'd1, 4'd2, 8'h4C, 32'd2},    // R2 1 Hz strobe
    '{2'd0, 4'd2, 8'hCC, 32'h84},
    '{2'd2, 4'd2, 8'd3,  32'h08},
    '{2'd1, 4'd2, 8'h4C, 32'd5},    // R2 1 MHz strobe
    '{2'd1, 4'd2, 8'h40, 32'd18}    // R2
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  tick_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;

  tmr_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i), .re_i(re_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i); #1;
    we_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    #1 v = rdata_o;
    @(posedge clk_i); #1;
    re_i = 1'b0;
    check(req, v, exp);
  endtask

  task automatic pulse(input int n, input logic [4:0] m);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      tick_i = m;
      @(posedge clk_i); #1;
      tick_i = '0;
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    @(negedge clk_i);
    #1 check(req, 32'(irq_o), 32'(exp));
  endtask

  initial begin
    #(PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd("R1", 8'h40, 0); rd("R1", 8'h44, 0); rd("R1", 8'h5C, 0);
    rd("R1", 8'h80, 0); rd("R1", 8'h9C, 0); rd("R1", 8'hC0, 0);
    rd("R1", 8'hDC, 0); rd("R1", 8'h14, 0); rd("R1", 8'h1C, 0);
    rd("R1", 8'h20, 0); chk_irq("R1", 1'b0);

    for (int s = 0; s < NSTEP; s++) begin
      case (STEPS[s].op)
        2'd0: wr(STEPS[s].a, STEPS[s].d);
        2'd1: rd($sformatf("R%0d step %0d", STEPS[s].req, s), STEPS[s].a, STEPS[s].d);
        default: pulse(int'(STEPS[s].a), STEPS[s].d[4:0]);
      endcase
    end

    // R4 write beats a same-cycle strobe
    do_reset();
    wr(8'hC0, 32'h01);
    @(negedge clk_i);
    tick_i = 5'h01; we_i = 1'b1; addr_i = 8'h40; wdata_i = 32'h10;
    @(posedge clk_i); #1;
    tick_i = '0; we_i = 1'b0;
    rd("R4", 8'h40, 32'h10);
    pulse(1, 5'h01);
    rd("R4", 8'h40, 32'h11);

    // R6 R7 R9 R10: ch5 shares counter 4, one-shot
    wr(8'h40, 0);
    wr(8'h1C, 32'hFF0);
    rd("R6", 8'h1C, 32'hFF0);
    wr(8'hC4, 32'h00);
    wr(8'h84, 32'd3);
    pulse(2, 5'h01);
    rd("R6", 8'h14, 0);
    chk_irq("R10", 1'b0);
    pulse(1, 5'h01);
    rd("R7", 8'h14, 32'h20);
    chk_irq("R10", 1'b1);
    wr(8'h14, 32'h20);
    rd("R10", 8'h14, 0);
    chk_irq("R10", 1'b0);
    wr(8'h40, 0);
    pulse(3, 5'h01);
    rd("R9", 8'h14, 0);

    // R8 R9: ch7 own, periodic, clear on match
    wr(8'hCC, 32'hC9);
    wr(8'h8C, 32'd2);
    pulse(2, 5'h01);
    rd("R8", 8'h4C, 0);
    rd("R6", 8'h14, 32'h80);
    wr(8'h14, 32'h80);
    pulse(2, 5'h01);
    rd("R9", 8'h14, 32'h80);
    wr(8'h14, 32'h80);

    // R6 masked channel: ch6 matches with enable bit 6 off
    wr(8'h1C, 32'hFB0);
    wr(8'hC8, 32'h81);
    wr(8'h88, 32'd1);
    pulse(1, 5'h01);
    rd("R6", 8'h14, 0);
    chk_irq("R6", 1'b0);

    // R7 ch9 shares counter 6 (now 1)
    wr(8'hD4, 32'h00);
    wr(8'h94, 32'd3);
    pulse(2, 5'h01);
    rd("R7", 8'h14, 32'h280);
    rd("R7", 8'h54, 0);
    wr(8'h14, 32'hFFF);
    rd("R10", 8'h14, 0);

    // R11 snapshot
    wr(8'hD4, 32'h200);
    wr(8'h50, 32'h1234);
    rd("R11", 8'h54, 0);
    rd("R11", 8'h20, 32'h1234);
    wr(8'h58, 32'h55);
    rd("R11", 8'h5C, 0);
    rd("R11", 8'h20, 32'h1234);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule